// File: doc/BRIEF.md
# Token-Driven Operation Start Controller

This block is a small group of per-operation controllers for a distributed, dataflow-style control scheme. There is no central schedule. Each operation has its own controller, which records single-cycle dependency tokens on its own token inputs. Once every token required by that operation has been seen, the controller asks for the shared functional unit. It starts the operation when the unit is granted. When the operation completes, the controller emits one token to the successor operations.

All controllers in a group are bound to the same functional unit, and a fixed-priority arbiter inside the group decides which of them uses it. The unit stays with the winning operation until that operation completes. Completion is detected per operation, in one of two ways:

- For an operation with a latency parameter of zero (unknown latency), completion comes from a datapath done input.
- For an operation with a non-zero latency parameter, an internal counter times completion.

The set of required tokens is a per-operation mask parameter. Collected tokens are cleared at start, so tokens that return over a loop back edge can fire the next iteration. For several shared units, instantiate one group per unit.

Top module: `dep_exec_group`

## Requirements
- R1: After reset, `req_o`, `gnt_o`, `start_o` and `tok_o` are all zero and no tokens are held.
- R2: Token pulses on the required inputs of operation i are remembered across cycles. Operation i's token bits are `tok_in[i*N_TOK +: N_TOK]`, and the required set is `NEED[i*N_TOK +: N_TOK]`. `req_o[i]` rises in the cycle after the cycle in which the last missing required token is seen. Tokens on inputs outside the mask never raise `req_o[i]`.
- R3: `req_o[i]` stays low while any required token of operation i is still missing.
- R4: When the unit is free and several operations request it, the lowest index is granted.
- R5: Once granted, the unit stays with its operation until that operation's `tok_o` cycle. A waiting requester gets its `start_o` in that same cycle, and never earlier.
- R6: `start_o[i]` is a one-cycle pulse in the cycle in which `req_o[i]` and `gnt_o[i]` are first both high. At most one `gnt_o` bit is high at a time.
- R7: If `LAT[i*LW +: LW]` is zero, `tok_o[i]` pulses in the cycle after a cycle in which `done_in[i]` is high while the operation runs. `done_in[i]` has no effect while the operation is not running.
- R8: If `LAT[i*LW +: LW]` is L > 0, `tok_o[i]` pulses exactly L+1 cycles after `start_o[i]`, and `done_in[i]` is ignored.
- R9: The held tokens clear at start. Tokens seen in the start cycle or later are kept and trigger the next iteration once the operation returns to idle. Tokens consumed by a start never trigger a second start.
- R10: `tok_o[i]` is a one-cycle pulse, issued once per start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_in | input | N_OP*N_TOK | Dependency token pulses, N_TOK per operation |
| done_in | input | N_OP | Datapath completion, used by zero-latency-parameter operations |
| req_o | output | N_OP | Operation is waiting for the shared unit |
| gnt_o | output | N_OP | Arbiter grant, one-hot or zero |
| start_o | output | N_OP | One-cycle start pulse to the datapath |
| tok_o | output | N_OP | One-cycle token to successor operations |

## Verification
The bench uses four patterns:

- A single-token operation with fixed latency and a spurious done pulse. This separates counter-timed completion from done-driven completion.
- Required tokens spread over several cycles, with an unmasked token and a done pulse while idle mixed in. This shows that only the masked set fires the request and that early done pulses are ignored.
- Two operations triggered in the same cycle. This exposes the priority order and whether the grant is held for the full run.
- A token set completed again during the run. This tells a correct clear-at-start from a controller that loses back-edge tokens or refires on stale ones.

// File: rtl/dep_exec_group.sv
module dep_exec_group #(
  parameter int N_OP  = 3,
  parameter int N_TOK = 3,
  parameter int LW    = 8,
  parameter logic [N_OP*N_TOK-1:0] NEED = 9'b111_001_011,
  parameter logic [N_OP*LW-1:0]    LAT  = {8'd2, 8'd3, 8'd0}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_OP*N_TOK-1:0] tok_in,
  input  logic [N_OP-1:0]       done_in,
  output logic [N_OP-1:0]       req_o,
  output logic [N_OP-1:0]       gnt_o,
  output logic [N_OP-1:0]       start_o,
  output logic [N_OP-1:0]       tok_o
);
  localparam int IW = (N_OP > 1) ? $clog2(N_OP) : 1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RUN, S_DONE} st_t;

  logic [N_OP-1:0] fin;
  logic            own_vld;
  logic [IW-1:0]   own_idx;
  logic [IW-1:0]   pick_idx;
  logic [N_OP-1:0] pick_vec;

  // R4: lowest index wins among requesters
  always_comb begin
    pick_idx = '0;
    pick_vec = '0;
    for (int k = N_OP - 1; k >= 0; k--) begin
      if (req_o[k]) begin
        pick_idx = IW'(k);
        pick_vec = '0;
        pick_vec[k] = 1'b1;
      end
    end
  end

  // R5: grant held by the owner until completion
  assign gnt_o = own_vld ? ({{(N_OP-1){1'b0}}, 1'b1} << own_idx) : pick_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_vld <= 1'b0;
      own_idx <= '0;
    end else if (own_vld && fin[own_idx]) begin
      own_vld <= 1'b0;
    end else if (|start_o) begin
      own_vld <= 1'b1;
      own_idx <= pick_idx;
    end
  end

  for (genvar g = 0; g < N_OP; g++) begin : g_op
    localparam logic [N_TOK-1:0] MASK = NEED[g*N_TOK +: N_TOK];
    localparam logic [LW-1:0]    L    = LAT[g*LW +: LW];

    st_t              st;
    logic [N_TOK-1:0] coll;
    logic [N_TOK-1:0] tk;
    logic [N_TOK-1:0] seen;

    assign tk         = tok_in[g*N_TOK +: N_TOK];
    assign seen       = coll | tk;
    assign req_o[g]   = (st == S_REQ);
    assign start_o[g] = req_o[g] & gnt_o[g];
    assign tok_o[g]   = (st == S_DONE);

    if (L == '0) begin : g_hs
      assign fin[g] = (st == S_RUN) & done_in[g];
    end else begin : g_cnt
      logic [LW-1:0] cnt;
      assign fin[g] = (st == S_RUN) && (cnt == LW'(1));
      always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (start_o[g])                 cnt <= L;
        else if (st == S_RUN && cnt != '0)   cnt <= cnt - LW'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st   <= S_IDLE;
        coll <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            coll <= seen;
            if ((seen & MASK) == MASK) st <= S_REQ;
          end
          S_REQ: begin
            if (gnt_o[g]) begin
              st   <= S_RUN;
              coll <= tk;
            end else begin
              coll <= seen;
            end
          end
          S_RUN: begin
            coll <= seen;
            if (fin[g]) st <= S_DONE;
          end
          default: begin
            coll <= seen;
            st   <= S_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dep_exec_group_chk.sv
module dep_exec_group_chk #(
  parameter int N_OP = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_OP-1:0] req_o,
  input logic [N_OP-1:0] gnt_o,
  input logic [N_OP-1:0] start_o,
  input logic [N_OP-1:0] tok_o
);
  a_r6_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != '0) |=> ((start_o & $past(start_o)) == '0));

  a_r10_tok_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_o != '0) |=> ((tok_o & $past(tok_o)) == '0));

  a_r5_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != '0) |=> (gnt_o == $past(start_o)));

  a_r4_low_index_first: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != '0) |-> ((req_o & (start_o - 1'b1)) == '0));

  a_r3_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_o & ~req_o) == '0));
endmodule

bind dep_exec_group dep_exec_group_chk #(.N_OP(N_OP)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_o(req_o), .gnt_o(gnt_o),
  .start_o(start_o), .tok_o(tok_o)
);

// File: tb/dep_exec_group_tb_top.sv
`timescale 1ns/1ps
module dep_exec_group_tb_top;
  localparam int N_OP = 3, N_TOK = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_OP*N_TOK-1:0] tok_in = '0;
  logic [N_OP-1:0] done_in = '0;
  logic [N_OP-1:0] req_o, gnt_o, start_o, tok_o;

  dep_exec_group dut_i (.clk(clk), .rst_n(rst_n), .tok_in(tok_in), .done_in(done_in),
    .req_o(req_o), .gnt_o(gnt_o), .start_o(start_o), .tok_o(tok_o));

  always #2 clk = ~clk;

  typedef struct { int cyc; int bitn; string tag; } exp_t;
  exp_t sb[$];
  int cyc = 0, nvec = 0, nbad = 0;
  bit mon_on = 1'b0, fin_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // bit 0..2 = start_o[op], bit 3..5 = tok_o[op]
  task automatic expect_ev(int c, int kind, int op, string tag);
    exp_t e;
    e.cyc = c; e.bitn = kind * 3 + op; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      logic [5:0] obs, ex;
      string tags[6];
      obs = {tok_o, start_o};
      ex = '0;
      for (int b = 0; b < 6; b++) tags[b] = (b < 3) ? "R6 unexpected start" : "R10 unexpected token";
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        if (e.cyc < cyc) begin
          nbad++;
          $display("FAIL %s: stale expectation cycle %0d at %0d", e.tag, e.cyc, cyc);
        end else begin
          ex[e.bitn] = 1'b1;
          tags[e.bitn] = e.tag;
        end
      end
      nvec++;
      if (obs !== ex) begin
        nbad++;
        for (int b = 0; b < 6; b++)
          if (obs[b] !== ex[b])
            $display("FAIL %s: {tok,start} got %b expected %b (cycle %0d)", tags[b], obs, ex, cyc);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int w;
    step(3);
    rst_n = 1'b1;
    step();
    check("R1 req", 32'(req_o), 0);
    check("R1 gnt", 32'(gnt_o), 0);
    check("R1 start", 32'(start_o), 0);
    check("R1 tok", 32'(tok_o), 0);
    mon_on = 1'b1;
    step(2);

    // R8: op1 one token, latency 3, done ignored
    w = cyc;
    tok_in[3] = 1'b1;
    expect_ev(w + 1, 0, 1, "R2 op1 start");
    expect_ev(w + 5, 1, 1, "R8 op1 token after L+1");
    step(); tok_in = '0;
    step(); done_in[1] = 1'b1;
    step(); done_in[1] = 1'b0;
    step(10);

    // R3/R7: op0 tokens spread out, unmasked token, early done
    w = cyc;
    tok_in[0] = 1'b1; done_in[0] = 1'b1;
    expect_ev(w + 3, 0, 0, "R2 op0 start");
    expect_ev(w + 7, 1, 0, "R7 op0 token after done");
    step(); tok_in = '0; done_in = '0; tok_in[2] = 1'b1;
    check("R3 op0 waits", 32'(req_o[0]), 0);
    step(); tok_in = '0; tok_in[1] = 1'b1;
    check("R2 unmasked ignored", 32'(req_o[0]), 0);
    step(); tok_in = '0;
    check("R2 req after last token", 32'(req_o[0]), 1);
    step(3); done_in[0] = 1'b1;
    step(); done_in[0] = 1'b0;
    step(10);

    // R4/R5: op0 and op1 together
    w = cyc;
    tok_in[0] = 1'b1; tok_in[1] = 1'b1; tok_in[3] = 1'b1;
    expect_ev(w + 1, 0, 0, "R4 op0 first");
    expect_ev(w + 4, 0, 1, "R5 op1 after op0 done");
    expect_ev(w + 4, 1, 0, "R7 op0 token");
    expect_ev(w + 8, 1, 1, "R8 op1 token");
    step(); tok_in = '0;
    step();
    check("R5 grant held op0", 32'(gnt_o), 1);
    check("R5 op1 waiting", 32'(req_o[1]), 1);
    step(); done_in[0] = 1'b1;
    step(); done_in[0] = 1'b0;
    step(10);

    // R9: op2 back-edge tokens
    w = cyc;
    tok_in[6] = 1'b1; tok_in[7] = 1'b1;
    expect_ev(w + 2, 0, 2, "R9 op2 first start");
    expect_ev(w + 5, 1, 2, "R8 op2 token");
    expect_ev(w + 7, 0, 2, "R9 op2 back-edge start");
    expect_ev(w + 10, 1, 2, "R10 op2 second token");
    step(); tok_in = '0; tok_in[8] = 1'b1;
    step(); tok_in = '0; tok_in[6] = 1'b1;
    step(); tok_in = '0; tok_in[7] = 1'b1; tok_in[8] = 1'b1;
    step(); tok_in = '0;
    step(20);
    check("R9 no refire", 32'(req_o), 0);
    check("R9 queue drained", 32'(sb.size()), 0);

    fin_done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin_done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule